// File: doc/BRIEF.md
# Routable stereo serial audio transmitter

The block takes pairs of 16-bit left/right audio samples from a valid/ready source and sends them out over a three-wire serial audio link made of a bit clock, a word-select strobe and one data line. The data is aligned as in standard I2S. The block can run as clock master, where it makes the bit clock and word select from the system clock through a divider. It can also run as a slave, where it follows a bit clock and word select that come from outside. Because samples come from a buffer, the output sample rate does not depend on how fast the source produces data.

Each output slot has its own source selector. The left slot and the right slot can each carry either input channel or digital silence, so the two channels can be swapped, one channel can be copied to both, or the output can be muted. The frame is 64 or 48 bit clocks long. A double-speed control halves the bit-clock period in master mode. A new sample pair, together with the routing that applies to it, is taken only when a left slot starts. If no pair is ready at that point, the block sends a silent frame and sets a sticky underrun flag.

Top module: `serial_audio_tx`

## Requirements
- R1: While rst_ni is low, and right after it is released, bclk_o, ws_o, sd_o, sample_ready_o and underrun_o are all 0.
- R2: With ratio48_i=0, every slot is 32 bit clocks long. The slot holds 16 data bits sent MSB first, followed by 16 zero bits. The MSB comes one bit clock after a ws_o transition. ws_o is 0 for the left slot and 1 for the right slot. A receiver samples on the rising edge of the bit clock.
- R3: With ratio48_i=1, every slot is 24 bit clocks long: 16 data bits MSB first, then 8 zero bits, with the same alignment as in R2.
- R4: The route_left_i code selects what the left slot carries: 2'b00 gives the left input, 2'b01 gives the right input, and 2'b10 gives zero.
- R5: The route_right_i code selects what the right slot carries: 2'b00 gives the right input, 2'b01 gives the left input, and 2'b10 gives zero.
- R6: The reserved code 2'b11 on either selector mutes that slot, so the slot carries zero.
- R7: In master mode (master_i=1), the period of bclk_o is 2*DIV_HALF clk_i cycles. This is 8 cycles by default. With dbl_speed_i=1 the period is DIV_HALF cycles, which is 4 by default.
- R8: In slave mode (master_i=0), sd_o follows bclk_ext_i and ws_ext_i with the same alignment as in R2. bclk_o and ws_o stay at 0.
- R9: sample_ready_o pulses for one cycle at the start of each left slot. A pair is accepted only on that pulse, so each frame takes exactly one pair. A routing change takes effect from the next frame; the frame already latched keeps the routing it was latched with.
- R10: If sample_valid_i is low at the ready pulse, both slots of that frame carry zero and underrun_o becomes 1. underrun_o stays 1 until reset, even after data starts arriving again.
- R11: In master mode, sd_o and ws_o change only in the cycle where bclk_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | A sample pair is available |
| sample_left_i | input | 16 | Left input sample |
| sample_right_i | input | 16 | Right input sample |
| sample_ready_o | output | 1 | Pulse that accepts a pair at the start of a frame |
| route_left_i | input | 2 | Source selector for the left slot |
| route_right_i | input | 2 | Source selector for the right slot |
| ratio48_i | input | 1 | 1: 48 bit clocks per frame; 0: 64 |
| master_i | input | 1 | 1: the block generates the link clocks; 0: it follows external clocks |
| dbl_speed_i | input | 1 | Halves the bit-clock period in master mode |
| bclk_ext_i | input | 1 | External bit clock used in slave mode |
| ws_ext_i | input | 1 | External word select used in slave mode |
| bclk_o | output | 1 | Bit clock output in master mode |
| ws_o | output | 1 | Word select output in master mode |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
In master mode, sd_o and ws_o change on the same clk_i edge on which bclk_o falls. In slave mode they change about three clk_i cycles after the external bit clock falls, because of the two-stage synchronizer and the output register. The bench therefore decodes the link on each rising edge of the bit clock, half a bit period after the data has settled, and rebuilds slot lengths, data and padding from the word-select transitions. The ready pulse comes in the clk_i cycle of the first falling edge of the frame. underrun_o is due one cycle after a ready pulse that finds no data, so the bench reads flags and counts handshakes only after whole frames have been decoded.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    SRC_OWN   = 2'b00,
    SRC_OTHER = 2'b01,
    SRC_MUTE  = 2'b10,
    SRC_RSVD  = 2'b11
  } src_sel_e;
endpackage

// File: rtl/stx_route.sv
module stx_route #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] own_i,
  input  logic [DATA_W-1:0] other_i,
  output logic [DATA_W-1:0] word_o
);
  import stx_pkg::*;

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_OWN:   word_o = own_i;
      SRC_OTHER: word_o = other_i;
      default:   word_o = '0;  // mute and reserved
    endcase
  end
endmodule

// File: rtl/stx_clkgen.sv
module stx_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic dbl_speed_i,
  input  logic bclk_ext_i,
  input  logic ws_ext_i,
  output logic bclk_o,
  output logic fall_o,
  output logic ws_s_o
);
  localparam int CNT_W = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;

  logic [CNT_W-1:0] cnt_q, half_m1;
  logic             bclk_q, wrap;
  logic [1:0]       bsync_q, wsync_q;
  logic             bprev_q;

  assign half_m1 = dbl_speed_i ? CNT_W'(DIV_HALF/2 - 1) : CNT_W'(DIV_HALF - 1);
  assign wrap    = (cnt_q >= half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!master_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsync_q <= '0;
      wsync_q <= '0;
      bprev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[0], bclk_ext_i};
      wsync_q <= {wsync_q[0], ws_ext_i};
      bprev_q <= bsync_q[1];
    end
  end

  assign bclk_o = bclk_q;
  assign ws_s_o = wsync_q[1];
  assign fall_o = master_i ? (bclk_q & wrap) : (bprev_q & ~bsync_q[1]);
endmodule

// File: rtl/stx_framer.sv
module stx_framer #(
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 24,
  parameter int POS_W      = $clog2(2*SLOT_LONG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             ratio48_i,
  input  logic             fall_i,
  input  logic             ws_s_i,
  output logic [POS_W-1:0] pos_n_o,
  output logic [POS_W-1:0] slot_len_o,
  output logic             latch_o,
  output logic             ws_o
);
  logic [POS_W-1:0] pos_q, pos_inc, flen_m1, slen, p1;
  logic             ws_q, ws_seen_q;

  assign flen_m1 = ratio48_i ? POS_W'(2*SLOT_SHORT - 1) : POS_W'(2*SLOT_LONG - 1);
  assign slen    = ratio48_i ? POS_W'(SLOT_SHORT) : POS_W'(SLOT_LONG);
  assign pos_inc = (pos_q >= flen_m1) ? '0 : pos_q + 1'b1;

  always_comb begin
    pos_n_o = pos_inc;
    // slave: resynchronise the frame position on every external word-select edge
    if (!master_i && (ws_s_i != ws_seen_q))
      pos_n_o = ws_s_i ? (slen - 1'b1) : flen_m1;
    p1 = (pos_n_o >= flen_m1) ? '0 : pos_n_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= POS_W'(2*SLOT_LONG - 1);
      ws_q      <= 1'b0;
      ws_seen_q <= 1'b0;
    end else if (fall_i) begin
      pos_q     <= pos_n_o;
      ws_q      <= (p1 >= slen);  // word select leads the slot by one bit
      ws_seen_q <= ws_s_i;
    end
  end

  assign slot_len_o = slen;
  assign latch_o    = fall_i && (pos_n_o == '0);
  assign ws_o       = ws_q;
endmodule

// File: rtl/stx_serializer.sv
module stx_serializer #(
  parameter int DATA_W = 16,
  parameter int POS_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              latch_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [POS_W-1:0]  pos_n_i,
  input  logic [POS_W-1:0]  slot_len_i,
  output logic              sd_o,
  output logic              underrun_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] wl_q, wr_q, wl_n, wr_n, w_sel;
  logic [POS_W-1:0]  k;
  logic [IDX_W-1:0]  bi;
  logic              chan_r, bit_n, sd_q, urun_q;

  assign wl_n = latch_i ? (valid_i ? left_i : '0) : wl_q;
  assign wr_n = latch_i ? (valid_i ? right_i : '0) : wr_q;

  always_comb begin
    chan_r = (pos_n_i >= slot_len_i);
    k      = chan_r ? (pos_n_i - slot_len_i) : pos_n_i;
    w_sel  = chan_r ? wr_n : wl_n;
    bi     = IDX_W'(DATA_W - 1) - k[IDX_W-1:0];
    bit_n  = (k < POS_W'(DATA_W)) ? w_sel[bi] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_q   <= '0;
      wr_q   <= '0;
      sd_q   <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      if (latch_i) begin
        wl_q <= wl_n;
        wr_q <= wr_n;
        if (!valid_i) urun_q <= 1'b1;
      end
      if (fall_i) sd_q <= bit_n;
    end
  end

  assign sd_o       = sd_q;
  assign underrun_o = urun_q;
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int DATA_W     = 16,
  parameter int DIV_HALF   = 4,
  parameter int SLOT_LONG  = 32,
  parameter int SLOT_SHORT = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_left_i,
  input  logic [DATA_W-1:0] sample_right_i,
  output logic              sample_ready_o,
  input  logic [1:0]        route_left_i,
  input  logic [1:0]        route_right_i,
  input  logic              ratio48_i,
  input  logic              master_i,
  input  logic              dbl_speed_i,
  input  logic              bclk_ext_i,
  input  logic              ws_ext_i,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              underrun_o
);
  localparam int POS_W = $clog2(2*SLOT_LONG);
  localparam int NCH   = 2;

  logic             fall, ws_s, latch, ws_int, bclk_int;
  logic [POS_W-1:0] pos_n, slot_len;
  logic [DATA_W-1:0] in_w  [NCH];
  logic [DATA_W-1:0] out_w [NCH];
  logic [1:0]        sel_w [NCH];

  assign in_w[0]  = sample_left_i;
  assign in_w[1]  = sample_right_i;
  assign sel_w[0] = route_left_i;
  assign sel_w[1] = route_right_i;

  stx_clkgen #(.DIV_HALF(DIV_HALF)) i_clkgen (
    .clk_i, .rst_ni, .master_i, .dbl_speed_i, .bclk_ext_i, .ws_ext_i,
    .bclk_o(bclk_int), .fall_o(fall), .ws_s_o(ws_s)
  );

  stx_framer #(.SLOT_LONG(SLOT_LONG), .SLOT_SHORT(SLOT_SHORT), .POS_W(POS_W)) i_framer (
    .clk_i, .rst_ni, .master_i, .ratio48_i, .fall_i(fall), .ws_s_i(ws_s),
    .pos_n_o(pos_n), .slot_len_o(slot_len), .latch_o(latch), .ws_o(ws_int)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_route
    stx_route #(.DATA_W(DATA_W)) i_route (
      .sel_i(sel_w[c]), .own_i(in_w[c]), .other_i(in_w[NCH-1-c]), .word_o(out_w[c])
    );
  end

  stx_serializer #(.DATA_W(DATA_W), .POS_W(POS_W)) i_ser (
    .clk_i, .rst_ni, .fall_i(fall), .latch_i(latch), .valid_i(sample_valid_i),
    .left_i(out_w[0]), .right_i(out_w[1]), .pos_n_i(pos_n), .slot_len_i(slot_len),
    .sd_o, .underrun_o
  );

  assign sample_ready_o = latch;
  assign bclk_o         = bclk_int;
  assign ws_o           = master_i & ws_int;
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic sample_valid_i,
  input logic sample_ready_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic underrun_o
);
  // R10
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  // R10
  underrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(sample_ready_o && !sample_valid_i));

  // R9
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_ready_o |=> !sample_ready_o);

  // R11
  sd_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$stable(sd_o)) |-> $fell(bclk_o));

  // R11
  ws_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !$stable(ws_o)) |-> $fell(bclk_o));

  // R8
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !$past(master_i)) |-> (!bclk_o && !ws_o));
endmodule

bind serial_audio_tx serial_audio_tx_chk i_chk (.*);

// File: tb/test_serial_audio_tx.sv
`timescale 1ns/1ps
module test_serial_audio_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] s_l, s_r;
  logic s_valid, s_ready;
  logic [1:0] rl = 2'b00, rr = 2'b00;
  logic r48 = 1'b0, mst = 1'b1, dbl = 1'b0, bext = 1'b1, wext = 1'b0;
  logic bclk, ws, sd, urun;

  always #2.5 clk = ~clk;

  serial_audio_tx i_serial_audio_tx (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(s_valid), .sample_left_i(s_l),
    .sample_right_i(s_r), .sample_ready_o(s_ready), .route_left_i(rl), .route_right_i(rr),
    .ratio48_i(r48), .master_i(mst), .dbl_speed_i(dbl), .bclk_ext_i(bext), .ws_ext_i(wext),
    .bclk_o(bclk), .ws_o(ws), .sd_o(sd), .underrun_o(urun)
  );

  int n_run = 0, n_fail = 0;
  logic [15:0] pl [8], pr [8];
  int src_idx = 0, n_avail = 0;

  assign s_valid = (src_idx < n_avail);
  assign s_l = pl[src_idx[2:0]];
  assign s_r = pr[src_idx[2:0]];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) src_idx <= 0;
    else if (s_valid && s_ready) src_idx <= src_idx + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // link decoder, clocked by whichever bit clock is active
  logic dclk, dws;
  assign dclk = mst ? bclk : bext;
  assign dws  = mst ? ws : wext;
  int slot_s = 32;
  bit dec_on = 0, ws_last = 1, cur_ok = 0, cur_slot = 0, len_bad = 0, pad_bad = 0;
  int idx = 0, cap_n = 0;
  logic [31:0] sh = '0;
  logic [15:0] cap_l [16], cap_r [16];

  always @(posedge dclk) if (dec_on) begin
    sh = {sh[30:0], sd};
    idx++;
    if (dws != ws_last) begin
      if (cur_ok) begin
        if (idx != slot_s) len_bad = 1;
        if ((sh & ((32'h1 << (slot_s - 16)) - 1)) != 0) pad_bad = 1;
        if (cap_n < 16) begin
          if (cur_slot) cap_r[cap_n] = 16'(sh >> (slot_s - 16));
          else          cap_l[cap_n] = 16'(sh >> (slot_s - 16));
        end
        if (cur_slot) cap_n++;
      end
      cur_ok = 1; cur_slot = dws; idx = 0; sh = '0; ws_last = dws;
    end
  end

  // R11 monitor: sd/ws may only move when bclk falls
  logic p_sd = 0, p_ws = 0, p_bclk = 0;
  int edge_bad = 0;
  always @(negedge clk) begin
    if (rst_n && mst && ((sd != p_sd) || (ws != p_ws)) && !(p_bclk && !bclk)) edge_bad++;
    p_sd = sd; p_ws = ws; p_bclk = bclk;
  end

  task automatic do_reset();
    rst_n = 0;
    dec_on = 0;
    repeat (4) @(negedge clk);
    ws_last = 1; cur_ok = 0; idx = 0; cap_n = 0; len_bad = 0; pad_bad = 0; sh = '0;
    dec_on = 1;
    rst_n = 1;
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (cap_n < n && t < 40000) begin @(negedge clk); t++; end
    check(cap_n >= n, "watch frames", cap_n, n);
  endtask

  function automatic logic [15:0] route(input logic [1:0] sel, input logic [15:0] own, input logic [15:0] oth);
    return (sel == 2'b00) ? own : (sel == 2'b01) ? oth : 16'h0;
  endfunction

  task automatic load(input int seed);
    for (int i = 0; i < 8; i++) begin
      pl[i] = 16'(16'hA53C ^ (seed * 16'h1357) ^ (i * 16'h0F11));
      pr[i] = 16'(16'h8001 + (seed * 16'h2469) + (i * 16'h3C0F));
    end
  endtask

  task automatic chk_frames(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [15:0] el, er;
      el = (i < n_avail) ? route(rl, pl[i], pr[i]) : 16'h0;
      er = (i < n_avail) ? route(rr, pr[i], pl[i]) : 16'h0;
      check(cap_l[i] == el, {tag, " left"}, cap_l[i], el);
      check(cap_r[i] == er, {tag, " right"}, cap_r[i], er);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; mst = 1;
    repeat (3) @(negedge clk);
    check({bclk, ws, sd, s_ready, urun} == 5'b0, "R1 in reset", {bclk, ws, sd, s_ready, urun}, 0);
    rst_n = 1;
    @(negedge clk);
    check({ws, sd, s_ready, urun} == 4'b0, "R1 after release", {ws, sd, s_ready, urun}, 0);
  endtask

  task automatic t_basic64();
    load(1); rl = 2'b00; rr = 2'b00; r48 = 0; slot_s = 32; n_avail = 4;
    do_reset(); wait_frames(3);
    chk_frames(3, "R2 R4 R5 default");
    check(!len_bad && !pad_bad, "R2 slot 32 pad", {len_bad, pad_bad}, 0);
    check(src_idx == 3 || src_idx == 4, "R9 one pair per frame", src_idx, 3);
    check(edge_bad == 0, "R11 edges", edge_bad, 0);
  endtask

  task automatic t_route(input logic [1:0] a, input logic [1:0] b, input string tag);
    load(2 + a + 4*b); rl = a; rr = b; r48 = 0; slot_s = 32; n_avail = 4;
    do_reset(); wait_frames(2);
    chk_frames(2, tag);
  endtask

  task automatic t_48();
    load(7); rl = 2'b01; rr = 2'b00; r48 = 1; slot_s = 24; n_avail = 4;
    do_reset(); wait_frames(3);
    chk_frames(3, "R3 48fs");
    check(!len_bad && !pad_bad, "R3 slot 24 pad", {len_bad, pad_bad}, 0);
    r48 = 0;
  endtask

  task automatic t_underrun();
    load(3); rl = 2'b00; rr = 2'b00; slot_s = 32; n_avail = 0;
    do_reset();
    check(urun == 0, "R10 clear after reset", urun, 0);
    wait_frames(2);
    chk_frames(2, "R10 silent");
    check(urun == 1, "R10 flag set", urun, 1);
    n_avail = 2;
    wait_frames(5);
    check(urun == 1, "R10 sticky", urun, 1);
    check(src_idx == 2, "R10 resume consumed", src_idx, 2);
  endtask

  task automatic t_speed(input bit d, input real exp_ns, input string tag);
    realtime t0, t1;
    load(4); dbl = d; n_avail = 2; slot_s = 32;
    do_reset();
    @(posedge bclk); @(posedge bclk); t0 = $realtime;
    @(posedge bclk); t1 = $realtime;
    check((t1 - t0) == exp_ns, tag, int'(t1 - t0), int'(exp_ns));
    wait_frames(1);
    chk_frames(1, {tag, " data"});
    dbl = 0;
  endtask

  task automatic t_route_change();
    int c;
    load(5); rl = 2'b00; rr = 2'b00; slot_s = 32; n_avail = 8;
    do_reset(); wait_frames(1);
    @(posedge ws);
    c = src_idx;
    rr = 2'b10;
    wait_frames(c + 1);
    check(cap_r[c-1] == pr[c-1], "R9 latched frame keeps route", cap_r[c-1], pr[c-1]);
    check(cap_r[c] == 16'h0, "R9 next frame muted", cap_r[c], 0);
    check(cap_l[c] == pl[c], "R9 left unaffected", cap_l[c], pl[c]);
    rr = 2'b00;
  endtask

  task automatic t_slave();
    int qbad = 0;
    load(6); rl = 2'b01; rr = 2'b01; slot_s = 32; n_avail = 3;
    mst = 0; bext = 1; wext = 0;
    do_reset();
    repeat (4) @(negedge clk);
    for (int f = 0; f < 3; f++)
      for (int p = 0; p < 64; p++) begin
        bext = 0; wext = (((p + 1) % 64) >= 32);
        repeat (8) @(negedge clk);
        if (bclk || ws) qbad++;
        bext = 1;
        repeat (8) @(negedge clk);
      end
    check(cap_n >= 2, "R8 slave frames", cap_n, 2);
    chk_frames(2, "R8 slave");
    check(qbad == 0, "R8 outputs quiet", qbad, 0);
    mst = 1; rl = 2'b00; rr = 2'b00;
  endtask

  initial begin
    #900us;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic64();
    t_route(2'b01, 2'b01, "R4 R5 swap");
    t_route(2'b00, 2'b01, "R4 R5 dup left");
    t_route(2'b10, 2'b00, "R4 mute left");
    t_route(2'b01, 2'b10, "R5 mute right");
    t_route(2'b11, 2'b11, "R6 reserved");
    t_48();
    t_underrun();
    t_speed(0, 40.0, "R7 single");
    t_speed(1, 20.0, "R7 double");
    t_route_change();
    t_slave();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule